// File: doc/BRIEF.md
# Selectable-Schedule Multiply-Add Engine

This block evaluates one fixed arithmetic expression over seven operand words and lets the caller pick, at each launch, how much of that expression is evaluated within a single clock period. Two mirror-image lanes each pass a source word through a copy step, multiply it by a first coefficient and multiply that product by a second coefficient. The two lane products are summed, and an addend is added to form the result.

One datapath serves every schedule. A schedule code chosen at launch decides which intermediate values are held in registers between states and which are passed straight on through combinational logic. A caller that can tolerate a long combinational path gets its answer in fewer clock cycles. A caller that needs a short path spends more cycles. The caller raises `start` for one cycle with operands and a schedule code, then waits for the one-cycle `done` pulse. After that, `result` holds the answer.

Top module: `sched_madd`

## Requirements
- R1: `result` equals `addend + L + R` modulo 2^32. For each lane (left and right), `L` is formed from that lane's own source, coefficient A and coefficient B as `(((src[15:0]*coefA[15:0]) mod 2^16) * coefB[15:0])`, and `R` is formed the same way. All factors are unsigned 16-bit values, so the upper 16 bits of the source and coefficient inputs have no effect.
- R2: With `sched` = 0 (all steps registered), `done` rises 5 cycles after the edge that accepts `start`.
- R3: With `sched` = 1 (only the two additions chained), `done` rises 4 cycles after acceptance.
- R4: With `sched` = 2 (copy chained into the first multiply, the additions chained), `done` rises 3 cycles after acceptance.
- R5: With `sched` = 3 (everything chained), `done` rises 1 cycle after acceptance.
- R6: `done` is high for exactly one cycle. `result` changes only on the edge that raises `done`, and otherwise holds its value.
- R7: While `busy` is high, `start`, `sched` and all operand inputs are ignored. Neither the result nor the latency of the running job changes.
- R8: After reset, `busy`, `done` and `result` are all 0.
- R9: `busy` rises on the edge that accepts `start` while idle. `busy` is low in the cycle where `done` is high, so a new job may be launched in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, sampled while idle |
| sched | input | 2 | Schedule code: 0 none, 1 adds chained, 2 one-multiplier chaining, 3 full chaining |
| leftSrc | input | 32 | Left lane source word (low 16 bits used) |
| leftCoefA | input | 32 | Left lane first coefficient (low 16 bits used) |
| leftCoefB | input | 32 | Left lane second coefficient (low 16 bits used) |
| rightSrc | input | 32 | Right lane source word (low 16 bits used) |
| rightCoefA | input | 32 | Right lane first coefficient (low 16 bits used) |
| rightCoefB | input | 32 | Right lane second coefficient (low 16 bits used) |
| addend | input | 32 | Word added to the lane sum |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Final sum, held until the next completion |

## Verification
The assertions assume that the schedule code seen at the accepting edge is the one the whole job must honour. They also assume that `start` may be held high or toggled arbitrarily during a job without consequence. Random stimulus exercises both assumptions. It keeps `start` asserted and scrambles every operand and the schedule code on every busy cycle of about half the jobs. Throughout, the bench still expects the latency and the result of the job that was launched. Directed cases add all-ones operands to expose use of the upper bits, all-zero operands, and sums that wrap past 2^32.

// File: rtl/sched_madd_pkg.sv
package sched_madd_pkg;

  typedef enum logic [1:0] {
    SCH_NONE   = 2'd0,
    SCH_ALU    = 2'd1,
    SCH_ONEMUL = 2'd2,
    SCH_FULL   = 2'd3
  } sched_e;

  localparam int STEP_W = 3;

  // Strobes from the sequencer to the datapath for one state.
  typedef struct packed {
    logic capture;
    logic wrCopy;
    logic wrMul1;
    logic wrMul2;
    logic wrSum;
    logic wrRes;
    logic fwdCopy;
    logic fwdMul1;
    logic fwdMul2;
    logic fwdSum;
  } stepCtl_t;

  function automatic logic [STEP_W-1:0] stepsFor(sched_e m);
    case (m)
      SCH_NONE:   stepsFor = STEP_W'(5);
      SCH_ALU:    stepsFor = STEP_W'(4);
      SCH_ONEMUL: stepsFor = STEP_W'(3);
      default:    stepsFor = STEP_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/sched_madd_ctrl.sv
module sched_madd_ctrl
  import sched_madd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] sched,
  output stepCtl_t   ctl,
  output logic       busy,
  output logic       done
);

  typedef enum logic {ST_IDLE, ST_RUN} phase_e;

  phase_e             phase;
  sched_e             schedQ;
  logic [STEP_W-1:0]  step;
  logic               lastStep;

  assign busy     = (phase == ST_RUN);
  assign lastStep = (step == stepsFor(schedQ) - STEP_W'(1));

  always_comb begin
    ctl         = '0;
    ctl.capture = (phase == ST_IDLE) && start;
    if (phase == ST_RUN) begin
      case (schedQ)
        SCH_NONE: begin
          ctl.wrCopy = (step == STEP_W'(0));
          ctl.wrMul1 = (step == STEP_W'(1));
          ctl.wrMul2 = (step == STEP_W'(2));
          ctl.wrSum  = (step == STEP_W'(3));
          ctl.wrRes  = (step == STEP_W'(4));
        end
        SCH_ALU: begin
          ctl.fwdSum = 1'b1;
          ctl.wrCopy = (step == STEP_W'(0));
          ctl.wrMul1 = (step == STEP_W'(1));
          ctl.wrMul2 = (step == STEP_W'(2));
          ctl.wrRes  = (step == STEP_W'(3));
        end
        SCH_ONEMUL: begin
          ctl.fwdCopy = 1'b1;
          ctl.fwdSum  = 1'b1;
          ctl.wrMul1  = (step == STEP_W'(0));
          ctl.wrMul2  = (step == STEP_W'(1));
          ctl.wrRes   = (step == STEP_W'(2));
        end
        default: begin
          ctl.fwdCopy = 1'b1;
          ctl.fwdMul1 = 1'b1;
          ctl.fwdMul2 = 1'b1;
          ctl.fwdSum  = 1'b1;
          ctl.wrRes   = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= ST_IDLE;
      schedQ <= SCH_NONE;
      step   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == ST_IDLE) begin
        if (start) begin
          phase  <= ST_RUN;
          schedQ <= sched_e'(sched);
          step   <= '0;
        end
      end else if (lastStep) begin
        phase <= ST_IDLE;
        done  <= 1'b1;
      end else begin
        step <= step + STEP_W'(1);
      end
    end
  end

endmodule

// File: rtl/sched_madd_lane.sv
module sched_madd_lane
  import sched_madd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MUL_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          ctl,
  input  logic [MUL_W-1:0]  srcQ,
  input  logic [MUL_W-1:0]  coefAQ,
  input  logic [MUL_W-1:0]  coefBQ,
  output logic [DATA_W-1:0] prodOut
);

  localparam int PROD_W = 2 * MUL_W;

  logic [MUL_W-1:0]  copyR, copyV;
  logic [MUL_W-1:0]  firstR, firstNew, firstV;
  logic [DATA_W-1:0] secondR, secondNew;
  logic [PROD_W-1:0] firstWide, secondWide;

  // Copy stage: either the held copy or the operand passed straight on.
  assign copyV = ctl.fwdCopy ? srcQ : copyR;

  // First multiply; only its low MUL_W bits feed the next multiplier.
  assign firstWide = PROD_W'(copyV) * PROD_W'(coefAQ);
  assign firstNew  = firstWide[MUL_W-1:0];
  assign firstV    = ctl.fwdMul1 ? firstNew : firstR;

  // Second multiply, full product width.
  assign secondWide = PROD_W'(firstV) * PROD_W'(coefBQ);
  assign secondNew  = DATA_W'(secondWide);
  assign prodOut    = ctl.fwdMul2 ? secondNew : secondR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      copyR   <= '0;
      firstR  <= '0;
      secondR <= '0;
    end else begin
      if (ctl.wrCopy) copyR   <= srcQ;
      if (ctl.wrMul1) firstR  <= firstNew;
      if (ctl.wrMul2) secondR <= secondNew;
    end
  end

endmodule

// File: rtl/sched_madd_dp.sv
module sched_madd_dp
  import sched_madd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MUL_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          ctl,
  input  logic [DATA_W-1:0] leftSrc,
  input  logic [DATA_W-1:0] leftCoefA,
  input  logic [DATA_W-1:0] leftCoefB,
  input  logic [DATA_W-1:0] rightSrc,
  input  logic [DATA_W-1:0] rightCoefA,
  input  logic [DATA_W-1:0] rightCoefB,
  input  logic [DATA_W-1:0] addend,
  output logic [DATA_W-1:0] result
);

  localparam int LANES = 2;

  logic [MUL_W-1:0]  srcIn   [LANES];
  logic [MUL_W-1:0]  coefAIn [LANES];
  logic [MUL_W-1:0]  coefBIn [LANES];
  logic [MUL_W-1:0]  srcQ    [LANES];
  logic [MUL_W-1:0]  coefAQ  [LANES];
  logic [MUL_W-1:0]  coefBQ  [LANES];
  logic [DATA_W-1:0] laneProd[LANES];
  logic [DATA_W-1:0] addendQ;
  logic [DATA_W-1:0] sumR, sumNew, sumV;
  logic              unusedHighBits;

  assign srcIn[0]   = leftSrc[MUL_W-1:0];
  assign coefAIn[0] = leftCoefA[MUL_W-1:0];
  assign coefBIn[0] = leftCoefB[MUL_W-1:0];
  assign srcIn[1]   = rightSrc[MUL_W-1:0];
  assign coefAIn[1] = rightCoefA[MUL_W-1:0];
  assign coefBIn[1] = rightCoefB[MUL_W-1:0];

  // Upper operand bits never reach a multiplier by definition.
  assign unusedHighBits = ^{leftSrc[DATA_W-1:MUL_W], leftCoefA[DATA_W-1:MUL_W],
                            leftCoefB[DATA_W-1:MUL_W], rightSrc[DATA_W-1:MUL_W],
                            rightCoefA[DATA_W-1:MUL_W], rightCoefB[DATA_W-1:MUL_W]};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcQ[g]   <= '0;
        coefAQ[g] <= '0;
        coefBQ[g] <= '0;
      end else if (ctl.capture) begin
        srcQ[g]   <= srcIn[g];
        coefAQ[g] <= coefAIn[g];
        coefBQ[g] <= coefBIn[g];
      end
    end

    sched_madd_lane #(
      .DATA_W(DATA_W),
      .MUL_W (MUL_W)
    ) i_lane (
      .clk    (clk),
      .rstN   (rstN),
      .ctl    (ctl),
      .srcQ   (srcQ[g]),
      .coefAQ (coefAQ[g]),
      .coefBQ (coefBQ[g]),
      .prodOut(laneProd[g])
    );
  end

  assign sumNew = laneProd[0] + laneProd[1];
  assign sumV   = ctl.fwdSum ? sumNew : sumR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addendQ <= '0;
      sumR    <= '0;
      result  <= '0;
    end else begin
      if (ctl.capture) addendQ <= addend;
      if (ctl.wrSum)   sumR    <= sumNew;
      if (ctl.wrRes)   result  <= addendQ + sumV;
    end
  end

endmodule

// File: rtl/sched_madd.sv
module sched_madd
  import sched_madd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MUL_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        sched,
  input  logic [DATA_W-1:0] leftSrc,
  input  logic [DATA_W-1:0] leftCoefA,
  input  logic [DATA_W-1:0] leftCoefB,
  input  logic [DATA_W-1:0] rightSrc,
  input  logic [DATA_W-1:0] rightCoefA,
  input  logic [DATA_W-1:0] rightCoefB,
  input  logic [DATA_W-1:0] addend,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  stepCtl_t ctl;

  sched_madd_ctrl i_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .sched(sched),
    .ctl  (ctl),
    .busy (busy),
    .done (done)
  );

  sched_madd_dp #(
    .DATA_W(DATA_W),
    .MUL_W (MUL_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .leftSrc   (leftSrc),
    .leftCoefA (leftCoefA),
    .leftCoefB (leftCoefB),
    .rightSrc  (rightSrc),
    .rightCoefA(rightCoefA),
    .rightCoefB(rightCoefB),
    .addend    (addend),
    .result    (result)
  );

endmodule

// File: rtl/sched_madd_chk.sv
module sched_madd_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [1:0]        sched,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] result
);

  logic [1:0] schedCap;
  logic [3:0] cyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      schedCap <= '0;
      cyc      <= '0;
    end else if (start && !busy) begin
      schedCap <= sched;
      cyc      <= '0;
    end else if (busy) begin
      cyc <= cyc + 4'd1;
    end
  end

  // R2
  lat_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && schedCap == 2'd0) |-> cyc == 4'd5);
  // R3
  lat_alu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && schedCap == 2'd1) |-> cyc == 4'd4);
  // R4
  lat_onemul_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && schedCap == 2'd2) |-> cyc == 4'd3);
  // R5
  lat_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && schedCap == 2'd3) |-> cyc == 4'd1);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);
  // R7
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !done) |=> (busy || done));
  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind sched_madd sched_madd_chk #(.DATA_W(DATA_W)) i_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .sched (sched),
  .busy  (busy),
  .done  (done),
  .result(result)
);

// File: tb/test_sched_madd.sv
module test_sched_madd;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  sched = 2'd0;
  logic [31:0] leftSrc = '0, leftCoefA = '0, leftCoefB = '0;
  logic [31:0] rightSrc = '0, rightCoefA = '0, rightCoefB = '0;
  logic [31:0] addend = '0;
  logic        busy, done;
  logic [31:0] result;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sched_madd i_sched_madd (
    .clk(clk), .rstN(rstN), .start(start), .sched(sched),
    .leftSrc(leftSrc), .leftCoefA(leftCoefA), .leftCoefB(leftCoefB),
    .rightSrc(rightSrc), .rightCoefA(rightCoefA), .rightCoefB(rightCoefB),
    .addend(addend), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [31:0] laneRef(logic [31:0] s, logic [31:0] a, logic [31:0] b);
    logic [31:0] p1;
    p1 = {16'd0, s[15:0]} * {16'd0, a[15:0]};
    return {16'd0, p1[15:0]} * {16'd0, b[15:0]};
  endfunction

  function automatic logic [31:0] resultRef(logic [31:0] ls, logic [31:0] la, logic [31:0] lb,
                                            logic [31:0] rs, logic [31:0] ra, logic [31:0] rb,
                                            logic [31:0] ad);
    return ad + laneRef(ls, la, lb) + laneRef(rs, ra, rb);
  endfunction

  function automatic int latencyRef(logic [1:0] m);
    case (m)
      2'd0: return 5;
      2'd1: return 4;
      2'd2: return 3;
      default: return 1;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic scramble();
    leftSrc = $urandom;  leftCoefA = $urandom;  leftCoefB = $urandom;
    rightSrc = $urandom; rightCoefA = $urandom; rightCoefB = $urandom;
    addend = $urandom;   sched = 2'($urandom);
  endtask

  task automatic runJob(logic [1:0] m, logic [31:0] ls, logic [31:0] la, logic [31:0] lb,
                        logic [31:0] rs, logic [31:0] ra, logic [31:0] rb,
                        logic [31:0] ad, bit disturb);
    logic [31:0] exp;
    logic [31:0] held;
    int cnt;
    int expLat;
    exp    = resultRef(ls, la, lb, rs, ra, rb, ad);
    expLat = latencyRef(m);
    @(negedge clk);
    sched = m; leftSrc = ls; leftCoefA = la; leftCoefB = lb;
    rightSrc = rs; rightCoefA = ra; rightCoefB = rb; addend = ad;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R9: busy follows an accepted start
    check(busy == 1'b1, "R9", 32'(busy), 32'd1);
    start = disturb;
    if (disturb) scramble();
    cnt = 0;
    while (cnt < 20) begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
      if (done) break;
      if (disturb) scramble();
    end
    start = 1'b0;
    // R2 R3 R4 R5: latency per schedule code
    case (m)
      2'd0: check(cnt == expLat, "R2", 32'(cnt), 32'(expLat));
      2'd1: check(cnt == expLat, "R3", 32'(cnt), 32'(expLat));
      2'd2: check(cnt == expLat, "R4", 32'(cnt), 32'(expLat));
      default: check(cnt == expLat, "R5", 32'(cnt), 32'(expLat));
    endcase
    // R1 and R7: value of the launched job, despite disturbance
    check(result == exp, disturb ? "R7" : "R1", result, exp);
    check(busy == 1'b0, "R9", 32'(busy), 32'd0);
    held = result;
    @(posedge clk);
    @(negedge clk);
    // R6: single-cycle pulse, result held
    check(done == 1'b0, "R6", 32'(done), 32'd0);
    check(result == held, "R6", result, held);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R8: reset state
    check(busy == 1'b0, "R8", 32'(busy), 32'd0);
    check(done == 1'b0, "R8", 32'(done), 32'd0);
    check(result == 32'd0, "R8", result, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && result == 32'd0, "R8", result, 32'd0);

    // Directed: every schedule on a fixed operand set
    for (int m = 0; m < 4; m++)
      runJob(2'(m), 32'd3, 32'd5, 32'd7, 32'd11, 32'd13, 32'd17, 32'd100, 1'b0);
    // R1: upper bits ignored, low-16 truncation of the first product
    for (int m = 0; m < 4; m++)
      runJob(2'(m), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
             32'hABCD_FFFF, 32'h1234_8001, 32'h0F0F_FFFF, 32'hFFFF_FFFF, 1'b0);
    // All zeros and wrap of the final sum
    runJob(2'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 1'b0);
    runJob(2'd3, 32'h0000_FFFF, 32'h0000_0001, 32'h0000_FFFF,
           32'h0000_FFFF, 32'h0000_0001, 32'h0000_FFFF, 32'hFFFF_FFF0, 1'b1);
    runJob(2'd2, 32'd9, 32'd9, 32'd9, 32'd1, 32'd1, 32'd1, 32'd5, 1'b1);

    // Random jobs, about half disturbed while busy
    for (int i = 0; i < 60; i++)
      runJob(2'($urandom), $urandom, $urandom, $urandom, $urandom, $urandom,
             $urandom, $urandom, 1'($urandom));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule